// File: doc/BRIEF.md
# Byte ALU with Carry Flags

This block is the arithmetic and logic stage of a small accumulator machine. Each cycle in which `op_vld` is high, it samples an operation code, the accumulator byte, a second operand byte and the incoming carry and auxiliary-carry flags. One clock later it presents the result byte and new carry, auxiliary-carry and overflow values, each with its own write-enable. The register file and the flag register stay outside the block. The surrounding datapath writes the result and any enabled flags back.

Arithmetic covers plain add, add with carry, increment and decrement. The logic set is AND, OR, complement, clear and rotate left. A decimal-adjust operation turns the accumulator into two packed BCD digits after a binary addition. Only the add-type operations and decimal adjust ever raise a flag write-enable. All other operations leave the flag register alone.

The output register has two named states. `ST_IDLE` holds when no operation was issued in the previous cycle. `ST_RESULT` holds for one cycle after an issued operation. Transitions: `ST_IDLE`→`ST_RESULT` on `op_vld`, `ST_RESULT`→`ST_RESULT` on another `op_vld` (back-to-back issue), `ST_RESULT`→`ST_IDLE` when `op_vld` is low, and any state→`ST_IDLE` on reset.

Top module: `byte_alu`

## Requirements
- R1: Operation codes are 0=add, 1=add with carry, 2=AND, 3=OR, 4=complement, 5=clear, 6=increment, 7=decrement, 8=rotate left, 9=decimal adjust. An operation issued with `op_vld` high shows its result and enables on the outputs in the next cycle, with `res_vld` high. In a cycle after `op_vld` was low, and after reset, `res_vld` and all three write-enables are 0.
- R2: Add and add with carry raise all three flag write-enables. Carry is the carry out of bit 7. Auxiliary carry is the carry out of bit 3. Overflow is the XOR of the carries out of bits 6 and 7.
- R3: Add with carry sums accumulator, operand and `cy_in`. Plain add ignores `cy_in`.
- R4: AND and OR give the bitwise result of accumulator and operand and raise no flag write-enable.
- R5: Increment wraps FFh to 00h and decrement wraps 00h to FFh. Neither raises a flag write-enable.
- R6: Rotate left moves bit 7 into bit 0 and every other bit up by one place, with no flag write-enable.
- R7: Complement inverts all eight accumulator bits and clear yields 00h. Neither raises a flag write-enable.
- R8: Decimal adjust adds 06h when the low nibble exceeds 9 or `ac_in` is set. It then adds 60h when the resulting high nibble exceeds 9, `cy_in` is set, or the first step carried out of bit 7.
- R9: Decimal adjust raises only the carry write-enable. The new carry is 1 when `cy_in` was 1 or either correction step carried out of bit 7, and it is never cleared from 1 to 0.
- R10: Codes 10 to 15 return the accumulator unchanged and raise no flag write-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_vld | input | 1 | Operation issued this cycle |
| op_code | input | 4 | Operation code (see R1) |
| acc_in | input | 8 | Accumulator byte |
| opnd_in | input | 8 | Second operand byte |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary-carry flag |
| res_out | output | 8 | Result byte |
| res_vld | output | 1 | Result valid (state `ST_RESULT`) |
| cy_out | output | 1 | New carry value |
| cy_we | output | 1 | Carry write-enable |
| ac_out | output | 1 | New auxiliary-carry value |
| ac_we | output | 1 | Auxiliary-carry write-enable |
| ov_out | output | 1 | New overflow value |
| ov_we | output | 1 | Overflow write-enable |

## Verification
Two pairs of functions can coincide in one operation, and the bench provokes both. In decimal adjust, the nibble correction and the high-digit correction can both apply: the accumulator 9Bh needs +06h and then +60h, and FAh carries out of the first step into the second. In an add, the carry out of bit 3 and the carry out of bit 7 can arise together, so the auxiliary carry, carry and overflow must each be judged separately (7Fh+01h, FFh+01h). Issue can also be back-to-back, and the bench checks that each result lands in its own cycle.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_CPL  = 4'd4,
        OP_CLR  = 4'd5,
        OP_INC  = 4'd6,
        OP_DEC  = 4'd7,
        OP_RL   = 4'd8,
        OP_DA   = 4'd9
    } alu_op_e;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } out_state_e;

    typedef struct packed {
        logic cy;
        logic cy_we;
        logic ac;
        logic ac_we;
        logic ov;
        logic ov_we;
    } flag_upd_t;

endpackage

// File: rtl/byte_alu_adder.sv
module byte_alu_adder
    import byte_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_half,
    output logic         c_pre,
    output logic         c_top
);
    localparam int HALF = W / 2;
    localparam int MIDW = W - 1 - HALF;

    logic [HALF:0] low_part;
    logic [MIDW:0] mid_part;
    logic [1:0]    top_part;

    always_comb begin
        low_part = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cin};
        mid_part = {1'b0, a[W-2:HALF]} + {1'b0, b[W-2:HALF]} + {{MIDW{1'b0}}, low_part[HALF]};
        top_part = {1'b0, a[W-1]} + {1'b0, b[W-1]} + {1'b0, mid_part[MIDW]};
        sum      = {top_part[0], mid_part[MIDW-1:0], low_part[HALF-1:0]};
        c_half   = low_part[HALF];
        c_pre    = mid_part[MIDW];
        c_top    = top_part[1];
    end

endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic
    import byte_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_CPL:  y = ~a;
            OP_CLR:  y = '0;
            OP_RL:   y = {a[W-2:0], a[W-1]};
            default: y = a;
        endcase
    end

endmodule

// File: rtl/byte_alu_decadj.sv
module byte_alu_decadj
    import byte_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic         cy,
    input  logic         ac,
    output logic [W-1:0] y,
    output logic         cy_new
);
    localparam int H = W / 2;
    localparam logic [H-1:0] DIGIT_MAX = H'(9);
    localparam logic [W:0]   LO_FIX    = (W+1)'(6);
    localparam logic [W:0]   HI_FIX    = (W+1)'(6) << H;

    logic [W:0] step_lo;
    logic [W:0] step_hi;
    logic       need_lo;
    logic       need_hi;

    always_comb begin
        need_lo = (a[H-1:0] > DIGIT_MAX) || ac;
        step_lo = need_lo ? ({1'b0, a} + LO_FIX) : {1'b0, a};
        need_hi = (step_lo[W-1:H] > DIGIT_MAX) || cy || step_lo[W];
        step_hi = need_hi ? ({1'b0, step_lo[W-1:0]} + HI_FIX) : {1'b0, step_lo[W-1:0]};
        y       = step_hi[W-1:0];
        cy_new  = cy | step_lo[W] | step_hi[W];
    end

endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import byte_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_vld,
    input  logic [3:0]   op_code,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] opnd_in,
    input  logic         cy_in,
    input  logic         ac_in,
    output logic [W-1:0] res_out,
    output logic         res_vld,
    output logic         cy_out,
    output logic         cy_we,
    output logic         ac_out,
    output logic         ac_we,
    output logic         ov_out,
    output logic         ov_we
);
    alu_op_e    op;
    out_state_e state_q, state_d;

    logic [W-1:0] add_b;
    logic         add_cin;
    logic [W-1:0] add_sum;
    logic         add_c3, add_c6, add_c7;
    logic [W-1:0] logic_y;
    logic [W-1:0] da_y;
    logic         da_cy;

    logic [W-1:0] res_d;
    flag_upd_t    flg_d;
    logic [W-1:0] res_q;
    flag_upd_t    flg_q;

    assign op = alu_op_e'(op_code);

    // operand steering for the shared adder
    always_comb begin
        unique case (op)
            OP_ADD:  begin add_b = opnd_in; add_cin = 1'b0;  end
            OP_ADDC: begin add_b = opnd_in; add_cin = cy_in; end
            OP_INC:  begin add_b = '0;      add_cin = 1'b1;  end
            OP_DEC:  begin add_b = '1;      add_cin = 1'b0;  end
            default: begin add_b = '0;      add_cin = 1'b0;  end
        endcase
    end

    byte_alu_adder #(.W(W)) u_add (
        .a      (acc_in),
        .b      (add_b),
        .cin    (add_cin),
        .sum    (add_sum),
        .c_half (add_c3),
        .c_pre  (add_c6),
        .c_top  (add_c7)
    );

    byte_alu_logic #(.W(W)) u_log (
        .op (op),
        .a  (acc_in),
        .b  (opnd_in),
        .y  (logic_y)
    );

    byte_alu_decadj #(.W(W)) u_da (
        .a      (acc_in),
        .cy     (cy_in),
        .ac     (ac_in),
        .y      (da_y),
        .cy_new (da_cy)
    );

    // result and flag selection
    always_comb begin
        flg_d = '0;
        unique case (op)
            OP_ADD, OP_ADDC: begin
                res_d       = add_sum;
                flg_d.cy    = add_c7;
                flg_d.cy_we = 1'b1;
                flg_d.ac    = add_c3;
                flg_d.ac_we = 1'b1;
                flg_d.ov    = add_c6 ^ add_c7;
                flg_d.ov_we = 1'b1;
            end
            OP_INC, OP_DEC: res_d = add_sum;
            OP_AND, OP_OR, OP_CPL, OP_CLR, OP_RL: res_d = logic_y;
            OP_DA: begin
                res_d       = da_y;
                flg_d.cy    = da_cy;
                flg_d.cy_we = 1'b1;
            end
            default: res_d = acc_in;
        endcase
    end

    // next state
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = op_vld ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = op_vld ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            flg_q <= '0;
        end else if (op_vld) begin
            res_q <= res_d;
            flg_q <= flg_d;
        end else begin
            flg_q.cy_we <= 1'b0;
            flg_q.ac_we <= 1'b0;
            flg_q.ov_we <= 1'b0;
        end
    end

    assign res_out = res_q;
    assign res_vld = (state_q == ST_RESULT);
    assign cy_out  = flg_q.cy;
    assign cy_we   = flg_q.cy_we;
    assign ac_out  = flg_q.ac;
    assign ac_we   = flg_q.ac_we;
    assign ov_out  = flg_q.ov;
    assign ov_we   = flg_q.ov_we;

endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk
    import byte_alu_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       op_vld,
    input logic [3:0] op_code,
    input logic [7:0] acc_in,
    input logic [7:0] opnd_in,
    input logic       cy_in,
    input logic       ac_in,
    input logic [7:0] res_out,
    input logic       res_vld,
    input logic       cy_out,
    input logic       cy_we,
    input logic       ac_out,
    input logic       ac_we,
    input logic       ov_out,
    input logic       ov_we
);
    p_vld_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld |=> res_vld);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !op_vld |=> (!res_vld && !cy_we && !ac_we && !ov_we));

    p_add_all_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_code <= 4'd1) |=> (cy_we && ac_we && ov_we));

    p_bitwise_no_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && (op_code == 4'd2 || op_code == 4'd3)) |=> (!cy_we && !ac_we && !ov_we));

    p_inc_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_code == 4'd6) |=> (res_out == 8'($past(acc_in) + 8'd1) && !cy_we));

    p_rotate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_code == 4'd8) |=> (res_out == {$past(acc_in[6:0]), $past(acc_in[7])}));

    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_code == 4'd5) |=> (res_out == 8'h00 && !ov_we));

    p_da_sticky_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_code == 4'd9 && cy_in) |=> (cy_we && cy_out && !ac_we && !ov_we));

    p_spare_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_code >= 4'd10) |=> (res_out == $past(acc_in) && !cy_we && !ac_we && !ov_we));

endmodule

bind byte_alu byte_alu_chk u_chk (.*);

// File: tb/tb_byte_alu.sv
module tb_byte_alu;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_vld = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] opnd_in = '0;
    logic       cy_in = 1'b0;
    logic       ac_in = 1'b0;
    logic [7:0] res_out;
    logic       res_vld, cy_out, cy_we, ac_out, ac_we, ov_out, ov_we;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    byte_alu dut (.*);

    // {op, acc, opnd, cy, ac, res, cy_we, cy, ac_we, ac, ov_we, ov}
    localparam int NV = 23;
    localparam logic [35:0] VEC [NV] = '{
        {4'd0, 8'h7F, 8'h01, 1'b1, 1'b0, 8'h80, 6'b10_11_11},
        {4'd0, 8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 6'b11_11_10},
        {4'd0, 8'h0A, 8'h06, 1'b0, 1'b0, 8'h10, 6'b10_11_10},
        {4'd1, 8'h80, 8'h80, 1'b1, 1'b0, 8'h01, 6'b11_10_11},
        {4'd1, 8'h0F, 8'h00, 1'b1, 1'b0, 8'h10, 6'b10_11_10},
        {4'd2, 8'hF0, 8'h3C, 1'b1, 1'b1, 8'h30, 6'b00_00_00},
        {4'd3, 8'hF0, 8'h0F, 1'b1, 1'b1, 8'hFF, 6'b00_00_00},
        {4'd4, 8'h5A, 8'h00, 1'b1, 1'b0, 8'hA5, 6'b00_00_00},
        {4'd5, 8'h77, 8'hFF, 1'b0, 1'b1, 8'h00, 6'b00_00_00},
        {4'd6, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 6'b00_00_00},
        {4'd6, 8'h41, 8'h00, 1'b1, 1'b1, 8'h42, 6'b00_00_00},
        {4'd7, 8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 6'b00_00_00},
        {4'd7, 8'h80, 8'h00, 1'b0, 1'b0, 8'h7F, 6'b00_00_00},
        {4'd8, 8'h81, 8'h00, 1'b0, 1'b0, 8'h03, 6'b00_00_00},
        {4'd8, 8'h40, 8'h00, 1'b1, 1'b0, 8'h80, 6'b00_00_00},
        {4'd9, 8'h9B, 8'h00, 1'b0, 1'b0, 8'h01, 6'b11_00_00},
        {4'd9, 8'h23, 8'h00, 1'b0, 1'b1, 8'h29, 6'b10_00_00},
        {4'd9, 8'h12, 8'h00, 1'b1, 1'b0, 8'h72, 6'b11_00_00},
        {4'd9, 8'hFA, 8'h00, 1'b0, 1'b0, 8'h60, 6'b11_00_00},
        {4'd9, 8'h45, 8'h00, 1'b0, 1'b0, 8'h45, 6'b10_00_00},
        {4'd9, 8'h00, 8'h00, 1'b1, 1'b1, 8'h66, 6'b11_00_00},
        {4'd15, 8'h3C, 8'hFF, 1'b1, 1'b1, 8'h3C, 6'b00_00_00},
        {4'd11, 8'hC3, 8'h12, 1'b0, 1'b0, 8'hC3, 6'b00_00_00}
    };

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0:       return "R2/R3";
            4'd1:       return "R2/R3";
            4'd2, 4'd3: return "R4";
            4'd4, 4'd5: return "R7";
            4'd6, 4'd7: return "R5";
            4'd8:       return "R6";
            4'd9:       return "R8/R9";
            default:    return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // {vld, res, cy_we, cy&we, ac_we, ac&we, ov_we, ov&we}, value bits masked when not enabled
    function automatic logic [14:0] obs();
        return {res_vld, res_out, cy_we, cy_out & cy_we, ac_we, ac_out & ac_we, ov_we, ov_out & ov_we};
    endfunction

    task automatic issue(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic c, input logic h);
        op_code = op; acc_in = a; opnd_in = b; cy_in = c; ac_in = h; op_vld = 1'b1;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [14:0] got;
        repeat (3) @(negedge clk);
        // R1: reset state
        got = obs();
        check("R1 reset", {got[14], 1'b0, got[5:0], 6'b0}, 14'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][35:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15], VEC[i][14]);
            @(negedge clk);
            op_vld = 1'b0;
            got = obs();
            check(req_of(VEC[i][35:32]), {got[14], got[13:6], got[5:1]}, {1'b1, VEC[i][13:6], VEC[i][5:1]});
            check(req_of(VEC[i][35:32]), {13'b0, got[0]}, {13'b0, VEC[i][0]});
        end

        // R1: idle cycle after an op clears valid and enables
        issue(4'd0, 8'h01, 8'h01, 1'b0, 1'b0);
        @(negedge clk);
        op_vld = 1'b0;
        @(negedge clk);
        got = obs();
        check("R1 idle", {got[14], 7'b0, got[5], got[3], got[1], 3'b0}, 14'b0);

        // R1/R2: back-to-back issue, ADD then DA, each in its own cycle
        issue(4'd0, 8'h56, 8'h45, 1'b0, 1'b0);
        @(negedge clk);
        got = obs();
        check("R1 b2b first", {got[14], got[13:6], got[5:1]}, {1'b1, 8'h9B, 5'b10_10_1});
        issue(4'd9, 8'h9B, 8'h00, 1'b0, 1'b0);
        @(negedge clk);
        op_vld = 1'b0;
        got = obs();
        check("R8 b2b second", {got[14], got[13:6], got[5:1]}, {1'b1, 8'h01, 5'b11_00_0});

        // R3: plain add ignores cy_in, add with carry uses it, same operands
        issue(4'd0, 8'h10, 8'h20, 1'b1, 1'b0);
        @(negedge clk);
        check("R3 add", {6'b0, res_out}, {6'b0, 8'h30});
        issue(4'd1, 8'h10, 8'h20, 1'b1, 1'b0);
        @(negedge clk);
        op_vld = 1'b0;
        check("R3 addc", {6'b0, res_out}, {6'b0, 8'h31});

        // R1: reset during a result clears outputs
        issue(4'd1, 8'hFF, 8'hFF, 1'b1, 1'b1);
        @(negedge clk);
        op_vld = 1'b0;
        rst_n = 1'b0;
        #1;
        got = obs();
        check("R1 mid reset", {got[14], got[13:6], got[5], got[3], got[1], 2'b0}, 14'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule